// File: doc/BRIEF.md
# Triggered Command Queue FIFO

This block is a four-slot ring of 32-bit command words placed between a host-side write port and a converter-side transfer engine. The host pushes one command per write. While the queue is triggered (a level input) and holds at least one entry, it presents the oldest entry to the transfer engine. That entry leaves the queue only in the cycle where the engine reports that its transfer has completed. Slots never move: a transfer pointer selects the oldest entry and a push pointer selects the next free slot.

Software can read the transfer index and the entry count, along with full and empty indications. Two sticky flags record a push that was dropped because the queue was full, and a cycle spent triggered with nothing to send. Each flag clears when software writes 1 to it. A refill request, suitable for a DMA channel or an interrupt, stays high while the queue is enabled and holds fewer entries than a programmable threshold. A synchronous flush returns both pointers and the count to zero.

Top module: `cmdq_top`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) the count and transfer index are 0, empty is 1, full is 0, both sticky flags are 0 and xfer_valid is 0.
- R2: A push stores the word in slot (transfer index + count) mod 4 and raises the count by one at the next edge; entries leave in the order they were pushed.
- R3: A host write with any byte-enable pattern (wr_be bit k covers bits 8k+7..8k) pushes exactly one whole entry; the enabled lanes read back unchanged, and the other lanes hold unspecified data.
- R4: A pop happens only at an edge where xfer_done and xfer_valid are both 1; the count then drops by one and the transfer index advances, wrapping from 3 to 0. xfer_done while xfer_valid is 0 has no effect.
- R5: xfer_valid equals trig AND NOT empty, with no clock delay; xfer_cmd shows the entry at the transfer index; xfer_block equals xfer_valid, so it is 0 whenever the queue is empty.
- R6: empty is 1 exactly when the count is 0; full is 1 exactly when the count is 4.
- R7: A push while full is dropped, leaves the count and index unchanged, and sets the sticky overflow flag at the next edge.
- R8: A push and a pop at the same edge leave the count unchanged while the transfer index advances and the new word enters the queue.
- R9: An edge where trig is 1 and the queue is empty sets the sticky underflow flag; being empty with trig at 0 does not set it.
- R10: clr_ovf and clr_udf at 1 clear their flag at the next edge; if the set condition holds in the same cycle, the flag stays 1.
- R11: flush at 1 sets the transfer index and the count to 0 at the next edge, discards any push or pop in that cycle and leaves both flags unchanged.
- R12: refill_req equals en AND (count < threshold), with no clock delay, where a threshold of 0 acts as 1 and one above 4 acts as 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Queue enable, gates the refill request |
| flush | input | 1 | Synchronous pointer and count clear |
| wr_en | input | 1 | Host push strobe |
| wr_be | input | 4 | Byte enables of the host write |
| wr_data | input | 32 | Command word to push |
| trig | input | 1 | Triggered state level |
| xfer_done | input | 1 | Transfer completion strobe from the engine |
| refill_thresh | input | 3 | Refill threshold, 1 to 4 entries |
| clr_ovf | input | 1 | Write-1-to-clear for the overflow flag |
| clr_udf | input | 1 | Write-1-to-clear for the underflow flag |
| xfer_valid | output | 1 | An entry is presented for transfer |
| xfer_cmd | output | 32 | Entry at the transfer index |
| xfer_block | output | 1 | Blocking indication toward lower-priority queues |
| xfer_idx | output | 2 | Transfer index status |
| count | output | 3 | Entry count status |
| full | output | 1 | Queue holds four entries |
| empty | output | 1 | Queue holds no entry |
| ovf_flag | output | 1 | Sticky overflow flag |
| udf_flag | output | 1 | Sticky underflow flag |
| refill_req | output | 1 | Request for more commands |

## Verification
xfer_valid, xfer_block, xfer_cmd and refill_req follow their inputs within the same cycle. The count, the index, full, empty and both flags change one edge after the push, pop, flush or clear that causes them. The bench drives every input on the falling edge, waits a short settle time and compares all outputs with a bench model. Each new input set therefore meets the state left by the previous rising edge, and the model advances only after the following rising edge.

// File: rtl/cmdq_pkg.sv
// Package: shared sizes for the triggered command queue.
// Assumes a 32-bit command word; depth is set per instance.
package cmdq_pkg;
    localparam int CMD_W = 32;
    typedef logic [CMD_W-1:0] cmd_t;
endpackage

// File: rtl/cmdq_ptrs.sv
// Module: transfer/push pointers and entry count of the ring.
// Assumes push is never requested while full and pop never while empty
// (the top qualifies both). Flush has priority over push and pop.
module cmdq_ptrs #(
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic             pop,
    output logic [PTR_W-1:0] rd_idx,
    output logic [PTR_W-1:0] wr_idx,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    // Next slot index with wrap at DEPTH.
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Advance pointers and count on push/pop, clear on reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_idx <= '0;
            wr_idx <= '0;
            count  <= '0;
        end else begin
            if (push) wr_idx <= bump(wr_idx);
            if (pop)  rd_idx <= bump(rd_idx);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Status decode from the count.
    always_comb begin
        empty = (count == '0);
        full  = (count == CNT_W'(DEPTH));
    end

    a_r2_push_slot: assert property (@(posedge clk) disable iff (!rst_n)
        32'(wr_idx) == ((32'(rd_idx) + 32'(count)) % DEPTH));
    a_r6_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        32'(count) <= DEPTH);
    a_r4_pop_advance: assert property (@(posedge clk) disable iff (!rst_n)
        pop && !push && !flush |=> (rd_idx == bump($past(rd_idx))) && (count == $past(count) - 1'b1));
    a_r8_same_edge: assert property (@(posedge clk) disable iff (!rst_n)
        push && pop && !flush |=> count == $past(count));
    a_r11_flush_zero: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0) && (rd_idx == '0));
endmodule

// File: rtl/cmdq_ring.sv
// Module: ring of command slots, written at wr_idx, read at rd_idx.
// Assumes the caller only writes a free slot. Slots carry no reset:
// an unread slot is never presented, since xfer_valid needs a count.
module cmdq_ring
    import cmdq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_idx,
    input  cmd_t             wr_data,
    input  logic [PTR_W-1:0] rd_idx,
    output cmd_t             rd_data
);
    cmd_t slot [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Capture the whole word when this slot is the push target.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == PTR_W'(g))) slot[g] <= wr_data;
        end
    end

    // Present the slot at the transfer index.
    always_comb rd_data = slot[rd_idx];
endmodule

// File: rtl/cmdq_status.sv
// Module: sticky overflow/underflow flags and the refill request.
// Assumes clear requests are single-cycle write-1 strobes; a set in the
// same cycle as a clear wins.
module cmdq_status #(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             flush,
    input  logic             push_req,
    input  logic             trig,
    input  logic             full,
    input  logic             empty,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] thresh,
    input  logic             clr_ovf,
    input  logic             clr_udf,
    output logic             ovf_flag,
    output logic             udf_flag,
    output logic             refill_req
);
    logic             ovf_set;
    logic             udf_set;
    logic [CNT_W-1:0] thr_eff;

    // Event decode and threshold clamp to 1..DEPTH.
    always_comb begin
        ovf_set = push_req && full && !flush;
        udf_set = trig && empty;
        if (thresh == '0)                     thr_eff = CNT_W'(1);
        else if (thresh > CNT_W'(DEPTH))      thr_eff = CNT_W'(DEPTH);
        else                                  thr_eff = thresh;
        refill_req = en && (count < thr_eff);
    end

    // Sticky flags: set has priority over write-1 clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
            udf_flag <= 1'b0;
        end else begin
            ovf_flag <= ovf_set || (ovf_flag && !clr_ovf);
            udf_flag <= udf_set || (udf_flag && !clr_udf);
        end
    end

    a_r7_overflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
        push_req && full && !flush |=> ovf_flag);
    a_r9_underflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
        trig && empty |=> udf_flag);
    a_r10_udf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        udf_flag && !clr_udf |=> udf_flag);
    a_r11_flush_keeps_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag && flush && !clr_ovf |=> ovf_flag);
endmodule

// File: rtl/cmdq_top.sv
// Module: four-entry triggered command queue (top).
// Assumes trig is a level and xfer_done is a one-cycle completion strobe
// meaningful only while xfer_valid is high. Partial host writes push a
// whole word; unenabled lanes hold whatever wr_data carried.
module cmdq_top
    import cmdq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int BE_W  = CMD_W / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             flush,
    input  logic             wr_en,
    input  logic [BE_W-1:0]  wr_be,
    input  logic [CMD_W-1:0] wr_data,
    input  logic             trig,
    input  logic             xfer_done,
    input  logic [CNT_W-1:0] refill_thresh,
    input  logic             clr_ovf,
    input  logic             clr_udf,
    output logic             xfer_valid,
    output logic [CMD_W-1:0] xfer_cmd,
    output logic             xfer_block,
    output logic [PTR_W-1:0] xfer_idx,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty,
    output logic             ovf_flag,
    output logic             udf_flag,
    output logic             refill_req
);
    logic             push;
    logic             pop;
    logic [PTR_W-1:0] wr_idx;
    logic             any_lane;

    // Qualify push/pop; byte enables only mark which lanes are meaningful.
    always_comb begin
        any_lane   = |wr_be;
        xfer_valid = trig && !empty;
        xfer_block = xfer_valid;
        push       = wr_en && !full && !flush;
        pop        = xfer_done && xfer_valid && !flush;
    end

    cmdq_ptrs #(.DEPTH(DEPTH)) i_ptrs (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (flush),
        .push   (push),
        .pop    (pop),
        .rd_idx (xfer_idx),
        .wr_idx (wr_idx),
        .count  (count),
        .full   (full),
        .empty  (empty)
    );

    cmdq_ring #(.DEPTH(DEPTH)) i_ring (
        .clk     (clk),
        .wr_en   (push),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (xfer_idx),
        .rd_data (xfer_cmd)
    );

    cmdq_status #(.DEPTH(DEPTH)) i_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .flush      (flush),
        .push_req   (wr_en),
        .trig       (trig),
        .full       (full),
        .empty      (empty),
        .count      (count),
        .thresh     (refill_thresh),
        .clr_ovf    (clr_ovf),
        .clr_udf    (clr_udf),
        .ovf_flag   (ovf_flag),
        .udf_flag   (udf_flag),
        .refill_req (refill_req)
    );

    a_r5_empty_unblocks: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !xfer_block && !xfer_valid);
    a_r4_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done && !trig && !wr_en && !flush |=> $stable(count) && $stable(xfer_idx));
    a_r3_partial_pushes: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && any_lane && !full && !flush && !pop |=> count == $past(count) + 1'b1);
endmodule

// File: tb/test_cmdq_top.sv
module test_cmdq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0, flush = 1'b0, wr_en = 1'b0, trig = 1'b0, xfer_done = 1'b0;
    logic [3:0]  wr_be = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  refill_thresh = 3'd1;
    logic        clr_ovf = 1'b0, clr_udf = 1'b0;
    logic        xfer_valid, xfer_block, full, empty, ovf_flag, udf_flag, refill_req;
    logic [31:0] xfer_cmd;
    logic [1:0]  xfer_idx;
    logic [2:0]  count;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // bench model
    logic [31:0] mq [4];
    logic [3:0]  mbe [4];
    int midx = 0, mcnt = 0;
    bit movf = 0, mudf = 0;

    always #10 clk = ~clk;

    cmdq_top i_cmdq_top (
        .clk(clk), .rst_n(rst_n), .en(en), .flush(flush), .wr_en(wr_en),
        .wr_be(wr_be), .wr_data(wr_data), .trig(trig), .xfer_done(xfer_done),
        .refill_thresh(refill_thresh), .clr_ovf(clr_ovf), .clr_udf(clr_udf),
        .xfer_valid(xfer_valid), .xfer_cmd(xfer_cmd), .xfer_block(xfer_block),
        .xfer_idx(xfer_idx), .count(count), .full(full), .empty(empty),
        .ovf_flag(ovf_flag), .udf_flag(udf_flag), .refill_req(refill_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lane_mask(input logic [3:0] be);
        logic [31:0] m = '0;
        for (int k = 0; k < 4; k++) if (be[k]) m[8*k +: 8] = 8'hFF;
        return m;
    endfunction

    function automatic int thr_clamp(input int t);
        if (t == 0) return 1;
        if (t > 4) return 4;
        return t;
    endfunction

    // One cycle: drive at falling edge, check, then advance the model.
    task automatic step(input bit i_en, input bit i_fl, input bit i_wr, input logic [3:0] i_be,
                        input logic [31:0] i_d, input bit i_tr, input bit i_dn,
                        input logic [2:0] i_th, input bit i_co, input bit i_cu);
        bit pop_m, push_m, full_m, empty_m;
        @(negedge clk);
        en = i_en; flush = i_fl; wr_en = i_wr; wr_be = i_be; wr_data = i_d;
        trig = i_tr; xfer_done = i_dn; refill_thresh = i_th; clr_ovf = i_co; clr_udf = i_cu;
        #1;
        empty_m = (mcnt == 0);
        full_m  = (mcnt == 4);
        chk("R2 count", 32'(count), 32'(mcnt));
        chk("R4 index", 32'(xfer_idx), 32'(midx));
        chk("R6 empty", 32'(empty), 32'(empty_m));
        chk("R6 full", 32'(full), 32'(full_m));
        chk("R5 valid", 32'(xfer_valid), 32'(i_tr && !empty_m));
        chk("R5 block", 32'(xfer_block), 32'(i_tr && !empty_m));
        if (!empty_m)
            chk("R3 cmd lanes", xfer_cmd & lane_mask(mbe[midx]), mq[midx] & lane_mask(mbe[midx]));
        chk("R7 ovf", 32'(ovf_flag), 32'(movf));
        chk("R9 udf", 32'(udf_flag), 32'(mudf));
        chk("R12 refill", 32'(refill_req), 32'(i_en && (mcnt < thr_clamp(int'(i_th)))));
        @(posedge clk);
        pop_m  = i_dn && i_tr && !empty_m && !i_fl;
        push_m = i_wr && !full_m && !i_fl;
        movf = (i_wr && full_m && !i_fl) || (movf && !i_co);
        mudf = (i_tr && empty_m) || (mudf && !i_cu);
        if (i_fl) begin
            midx = 0; mcnt = 0;
        end else begin
            if (push_m) begin
                mq[(midx + mcnt) % 4] = i_d;
                mbe[(midx + mcnt) % 4] = i_be;
            end
            if (pop_m) midx = (midx + 1) % 4;
            mcnt = mcnt + int'(push_m) - int'(pop_m);
        end
    endtask

    task automatic idle();
        step(1, 0, 0, 4'h0, 32'h0, 0, 0, 3'd1, 0, 0);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin mq[i] = '0; mbe[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        // R1: reset state
        chk("R1 count", 32'(count), 0);
        chk("R1 index", 32'(xfer_idx), 0);
        chk("R1 empty", 32'(empty), 1);
        chk("R1 full", 32'(full), 0);
        chk("R1 flags", {30'd0, ovf_flag, udf_flag}, 0);
        chk("R1 valid", 32'(xfer_valid), 0);
        rst_n = 1'b1;

        // R2/R6: fill to full, then R7: push while full
        for (int i = 0; i < 4; i++) step(1, 0, 1, 4'hF, 32'hA000_0000 + i, 0, 0, 3'd4, 0, 0);
        step(1, 0, 1, 4'hF, 32'hDEAD_BEEF, 0, 0, 3'd4, 0, 0);
        idle();
        chk("R7 dropped count", 32'(count), 4);
        // R4: done without trig is ignored
        step(1, 0, 0, 4'h0, 0, 0, 1, 3'd2, 0, 0);
        // R4: drain with trig, index wraps
        for (int i = 0; i < 4; i++) step(1, 0, 0, 4'h0, 0, 1, 1, 3'd2, 0, 0);
        // R9: empty while triggered sets underflow; R10: clear with set wins
        step(1, 0, 0, 4'h0, 0, 1, 0, 3'd3, 0, 1);
        step(1, 0, 0, 4'h0, 0, 0, 0, 3'd3, 1, 1);
        idle();
        chk("R10 flags cleared", {30'd0, ovf_flag, udf_flag}, 0);
        // R3: partial byte enables push whole entries
        step(1, 0, 1, 4'b0101, 32'h1122_3344, 0, 0, 3'd0, 0, 0);
        step(1, 0, 1, 4'b1000, 32'h5566_7788, 0, 0, 3'd7, 0, 0);
        // R8: push and pop at the same edge
        step(1, 0, 1, 4'hF, 32'hCAFE_0001, 1, 1, 3'd2, 0, 0);
        idle();
        chk("R8 count kept", 32'(count), 2);
        // R11: flush keeps flags, discards push
        step(1, 0, 1, 4'hF, 0, 0, 0, 3'd2, 0, 0);
        step(1, 0, 1, 4'hF, 0, 0, 0, 3'd2, 0, 0);
        step(1, 0, 1, 4'hF, 0, 0, 0, 3'd2, 0, 0);
        step(1, 1, 1, 4'hF, 32'h0BAD_0BAD, 1, 1, 3'd2, 0, 0);
        step(0, 0, 0, 4'h0, 0, 0, 0, 3'd2, 0, 0);
        chk("R11 flush count", 32'(count), 0);
        chk("R11 flush keeps ovf", 32'(ovf_flag), 1);

        // Constrained random mix
        void'($urandom(32'd12345));
        for (int n = 0; n < 4000; n++) begin
            step(($urandom % 8) != 0, ($urandom % 40) == 0, ($urandom % 2) == 0,
                 4'($urandom), $urandom, ($urandom % 3) != 0, ($urandom % 2) == 0,
                 3'($urandom), ($urandom % 10) == 0, ($urandom % 10) == 0);
        end
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule